// File: doc/BRIEF.md
# Temperature Event Output Controller

This block watches a stream of signed temperature samples and drives an active-low event output when a programmed condition is met. Each sample is a 12-bit two's complement value in steps of 0.0625 degree, qualified by a one-cycle valid strobe. Every sample is compared against an upper limit, a lower limit and a critical limit. A small register port holds the limits, a hysteresis amount, the operating mode and an enable bit. A status register reports the raw comparison flags and holds a write-one-to-clear event bit.

Three modes shape how the comparisons reach the output. In latched-interrupt mode an excursion outside the upper/lower window is held until software clears it. In comparator mode the output simply tracks the window. In critical-only mode only the critical limit matters. The critical comparison never latches and always releases through hysteresis: the critical state sets when a sample is above the critical limit. It releases only when a sample falls below the critical limit minus the hysteresis.

Top module: `tev_ctrl`

## Requirements
- R1: After reset, event_n is 1 and the control register (address 0) reads 0. The status register (address 5) reads 0. The upper and critical limits (addresses 1 and 3) read 0x07FF, the lower limit (address 2) reads 0x0800, and the hysteresis (address 4) reads 0.
- R2: When samp_valid is high, the next clock edge loads the status flags. Bit 1 is set when the sample is strictly greater than the upper limit. Bit 2 is set when it is strictly less than the lower limit. Bit 3 is set when it is strictly greater than the critical limit. All comparisons are signed. Without samp_valid the flags hold their values, and the enable bit does not gate them.
- R3: In comparator mode (control bits [2:1] = 1; code 3 behaves the same), event_n is 0 exactly when status bit 1 or bit 2 is set or the critical state is active. The output returns high by itself after an in-window sample.
- R4: In latched-interrupt mode (control bits [2:1] = 0), an out-of-window sample sets status bit 0, which drives event_n to 0. The bit stays set after in-window samples. Only a register write to address 5 with data bit 0 = 1 clears it; writing 0 has no effect. If a setting sample arrives in the same cycle as a clear, the set wins.
- R5: The critical state sets on a sample greater than the critical limit. It clears only on a sample strictly less than the critical limit minus the hysteresis (hysteresis is unsigned). It drives event_n to 0 in every mode while enabled and needs no software clear.
- R6: In critical-only mode (control bits [2:1] = 2), samples outside the upper/lower window leave event_n unchanged. event_n is 0 exactly while the critical state is active.
- R7: While control bit 0 (enable) is 0, event_n is 1. The first clock edge with enable 0 clears the latched event and the critical state.
- R8: Limits and hysteresis written through the register port read back in bits [11:0], with bits [15:12] zero. The control register reads back the enable and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_valid | input | 1 | Sample strobe |
| samp_temp | input | 12 | Signed sample, 0.0625 degree per step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| event_n | output | 1 | Active-low event output |

## Verification
Directed samples sit exactly on each limit and one step to either side. They show whether the comparisons are strict and signed. They also show whether the hysteresis release point is exclusive, which separates an off-by-one in the release arithmetic from a correct one. Each mode then receives the same excursion-and-return sequence. This distinguishes a latch that holds from one that follows the window, and shows whether window excursions leak into critical-only mode. The sequence is followed by clear writes with data bit 0 at 0 and at 1. Constrained random samples clustered around the limits are mixed with clear writes, mode changes and enable toggles. This catches ordering faults, such as a set colliding with a clear or a mode change while an event is held.

// File: rtl/tev_pkg.sv
package tev_pkg;
  localparam int TEV_TW = 12;
  localparam int TEV_HW = 12;
  localparam int TEV_EW = ((TEV_TW > TEV_HW) ? TEV_TW : TEV_HW) + 2;
  localparam int TEV_DW = 16;
  localparam int TEV_AW = 3;

  typedef enum logic [1:0] {
    MODE_INT  = 2'd0,
    MODE_CMP  = 2'd1,
    MODE_CRIT = 2'd2,
    MODE_RSVD = 2'd3
  } tev_mode_e;

  localparam logic [TEV_AW-1:0] ADDR_CTRL = 3'd0;
  localparam logic [TEV_AW-1:0] ADDR_HI   = 3'd1;
  localparam logic [TEV_AW-1:0] ADDR_LO   = 3'd2;
  localparam logic [TEV_AW-1:0] ADDR_CRIT = 3'd3;
  localparam logic [TEV_AW-1:0] ADDR_HYST = 3'd4;
  localparam logic [TEV_AW-1:0] ADDR_STAT = 3'd5;

  function automatic logic is_above(input logic signed [TEV_TW-1:0] t,
                                    input logic signed [TEV_TW-1:0] lim);
    return t > lim;
  endfunction

  function automatic logic is_below(input logic signed [TEV_TW-1:0] t,
                                    input logic signed [TEV_TW-1:0] lim);
    return t < lim;
  endfunction

  // true when the sample lies strictly under (crit - hyst), computed wide
  function automatic logic crit_release(input logic signed [TEV_TW-1:0] t,
                                        input logic signed [TEV_TW-1:0] crit,
                                        input logic [TEV_HW-1:0] hy);
    logic signed [TEV_EW-1:0] te;
    logic signed [TEV_EW-1:0] ce;
    logic signed [TEV_EW-1:0] he;
    te = TEV_EW'(t);
    ce = TEV_EW'(crit);
    he = $signed({{(TEV_EW-TEV_HW){1'b0}}, hy});
    return te < (ce - he);
  endfunction
endpackage

// File: rtl/tev_regs.sv
module tev_regs
  import tev_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [TEV_AW-1:0]        wr_addr,
  input  logic [TEV_DW-1:0]        wr_data,
  input  logic [TEV_AW-1:0]        rd_addr,
  output logic [TEV_DW-1:0]        rd_data,
  input  logic                     st_latch,
  input  logic                     st_hi,
  input  logic                     st_lo,
  input  logic                     st_crit,
  output logic                     ctrl_en,
  output tev_mode_e                ctrl_mode,
  output logic signed [TEV_TW-1:0] lim_hi,
  output logic signed [TEV_TW-1:0] lim_lo,
  output logic signed [TEV_TW-1:0] lim_crit,
  output logic [TEV_HW-1:0]        hyst,
  output logic                     clr_evt
);
  localparam logic signed [TEV_TW-1:0] TMAX = {1'b0, {(TEV_TW-1){1'b1}}};
  localparam logic signed [TEV_TW-1:0] TMIN = {1'b1, {(TEV_TW-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_mode <= MODE_INT;
      lim_hi    <= TMAX;
      lim_lo    <= TMIN;
      lim_crit  <= TMAX;
      hyst      <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: begin
          ctrl_en   <= wr_data[0];
          ctrl_mode <= tev_mode_e'(wr_data[2:1]);
        end
        ADDR_HI:   lim_hi   <= wr_data[TEV_TW-1:0];
        ADDR_LO:   lim_lo   <= wr_data[TEV_TW-1:0];
        ADDR_CRIT: lim_crit <= wr_data[TEV_TW-1:0];
        ADDR_HYST: hyst     <= wr_data[TEV_HW-1:0];
        default: ;
      endcase
    end
  end

  assign clr_evt = wr_en && (wr_addr == ADDR_STAT) && wr_data[0];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_CTRL: rd_data = {{(TEV_DW-3){1'b0}}, ctrl_mode, ctrl_en};
      ADDR_HI:   rd_data = {{(TEV_DW-TEV_TW){1'b0}}, lim_hi};
      ADDR_LO:   rd_data = {{(TEV_DW-TEV_TW){1'b0}}, lim_lo};
      ADDR_CRIT: rd_data = {{(TEV_DW-TEV_TW){1'b0}}, lim_crit};
      ADDR_HYST: rd_data = {{(TEV_DW-TEV_HW){1'b0}}, hyst};
      ADDR_STAT: rd_data = {{(TEV_DW-4){1'b0}}, st_crit, st_lo, st_hi, st_latch};
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tev_compare.sv
module tev_compare
  import tev_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     samp_valid,
  input  logic signed [TEV_TW-1:0] samp_temp,
  input  logic                     en,
  input  logic signed [TEV_TW-1:0] lim_hi,
  input  logic signed [TEV_TW-1:0] lim_lo,
  input  logic signed [TEV_TW-1:0] lim_crit,
  input  logic [TEV_HW-1:0]        hyst,
  output logic                     window_hit,
  output logic                     flag_hi,
  output logic                     flag_lo,
  output logic                     flag_crit,
  output logic                     crit_act
);
  logic hit_hi, hit_lo, hit_crit, rel_crit;

  assign hit_hi     = is_above(samp_temp, lim_hi);
  assign hit_lo     = is_below(samp_temp, lim_lo);
  assign hit_crit   = is_above(samp_temp, lim_crit);
  assign rel_crit   = crit_release(samp_temp, lim_crit, hyst);
  assign window_hit = hit_hi | hit_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_hi   <= 1'b0;
      flag_lo   <= 1'b0;
      flag_crit <= 1'b0;
    end else if (samp_valid) begin
      flag_hi   <= hit_hi;
      flag_lo   <= hit_lo;
      flag_crit <= hit_crit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crit_act <= 1'b0;
    end else if (!en) begin
      crit_act <= 1'b0;
    end else if (samp_valid) begin
      if (hit_crit)      crit_act <= 1'b1;
      else if (rel_crit) crit_act <= 1'b0;
    end
  end
endmodule

// File: rtl/tev_event.sv
module tev_event
  import tev_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  tev_mode_e mode,
  input  logic      samp_valid,
  input  logic      window_hit,
  input  logic      clr_evt,
  input  logic      flag_hi,
  input  logic      flag_lo,
  input  logic      crit_act,
  output logic      int_latch,
  output logic      evt_active
);
  logic set_req;
  assign set_req = samp_valid && window_hit && (mode == MODE_INT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       int_latch <= 1'b0;
    else if (!en)     int_latch <= 1'b0;
    else if (set_req) int_latch <= 1'b1;
    else if (clr_evt) int_latch <= 1'b0;
  end

  always_comb begin
    evt_active = 1'b0;
    if (en) begin
      case (mode)
        MODE_INT:  evt_active = int_latch | crit_act;
        MODE_CRIT: evt_active = crit_act;
        default:   evt_active = flag_hi | flag_lo | crit_act;
      endcase
    end
  end
endmodule

// File: rtl/tev_ctrl.sv
module tev_ctrl
  import tev_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_valid,
  input  logic [TEV_TW-1:0] samp_temp,
  input  logic              wr_en,
  input  logic [TEV_AW-1:0] wr_addr,
  input  logic [TEV_DW-1:0] wr_data,
  input  logic [TEV_AW-1:0] rd_addr,
  output logic [TEV_DW-1:0] rd_data,
  output logic              event_n
);
  logic                     ctrl_en;
  tev_mode_e                ctrl_mode;
  logic signed [TEV_TW-1:0] lim_hi, lim_lo, lim_crit;
  logic [TEV_HW-1:0]        hyst;
  logic                     clr_evt;
  logic                     window_hit, flag_hi, flag_lo, flag_crit, crit_act;
  logic                     int_latch, evt_active;

  tev_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .st_latch(int_latch), .st_hi(flag_hi), .st_lo(flag_lo), .st_crit(flag_crit),
    .ctrl_en(ctrl_en), .ctrl_mode(ctrl_mode), .lim_hi(lim_hi), .lim_lo(lim_lo),
    .lim_crit(lim_crit), .hyst(hyst), .clr_evt(clr_evt)
  );

  tev_compare u_cmp (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_temp($signed(samp_temp)),
    .en(ctrl_en), .lim_hi(lim_hi), .lim_lo(lim_lo), .lim_crit(lim_crit), .hyst(hyst),
    .window_hit(window_hit), .flag_hi(flag_hi), .flag_lo(flag_lo),
    .flag_crit(flag_crit), .crit_act(crit_act)
  );

  tev_event u_evt (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .mode(ctrl_mode), .samp_valid(samp_valid),
    .window_hit(window_hit), .clr_evt(clr_evt), .flag_hi(flag_hi), .flag_lo(flag_lo),
    .crit_act(crit_act), .int_latch(int_latch), .evt_active(evt_active)
  );

  assign event_n = ~evt_active;
endmodule

// File: rtl/tev_ctrl_chk.sv
module tev_ctrl_chk
  import tev_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     samp_valid,
  input logic signed [TEV_TW-1:0] samp_temp,
  input logic                     ctrl_en,
  input logic [1:0]               ctrl_mode,
  input logic signed [TEV_TW-1:0] lim_crit,
  input logic                     clr_evt,
  input logic                     window_hit,
  input logic                     flag_hi,
  input logic                     flag_lo,
  input logic                     flag_crit,
  input logic                     crit_act,
  input logic                     int_latch,
  input logic                     event_n
);
  p_flags_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_valid |=> $stable({flag_hi, flag_lo, flag_crit}));

  p_cmp_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && ctrl_mode == MODE_CMP && (flag_hi || flag_lo)) |-> !event_n);

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && int_latch && !clr_evt) |=> int_latch);

  p_latch_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && clr_evt && !(samp_valid && window_hit)) |=> !int_latch);

  p_crit_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && samp_valid && (samp_temp > lim_crit)) |=> crit_act);

  p_crit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && crit_act && !samp_valid) |=> crit_act);

  p_critonly_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && ctrl_mode == MODE_CRIT) |-> (event_n == !crit_act));

  p_off_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> event_n);
endmodule

bind tev_ctrl tev_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_temp($signed(samp_temp)),
  .ctrl_en(ctrl_en), .ctrl_mode(ctrl_mode), .lim_crit(lim_crit), .clr_evt(clr_evt),
  .window_hit(window_hit), .flag_hi(flag_hi), .flag_lo(flag_lo), .flag_crit(flag_crit),
  .crit_act(crit_act), .int_latch(int_latch), .event_n(event_n)
);

// File: tb/tev_ctrl_bench.sv
`timescale 1ns/1ps
module tev_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        samp_valid = 1'b0;
  logic [11:0] samp_temp = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = 3'd5;
  logic [15:0] rd_data;
  logic        event_n;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tev_ctrl u_tev_ctrl (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_temp(samp_temp),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .event_n(event_n)
  );

  // bench model, built from the requirements as integers
  bit m_en, m_fhi, m_flo, m_fcrit, m_cact, m_latch;
  int m_mode, m_hi, m_lo, m_crit, m_hyst;

  function automatic int sx12(input logic [11:0] v);
    return int'($signed(v));
  endfunction

  function automatic bit exp_event_n();
    bit act;
    if (!m_en) return 1'b1;
    if (m_mode == 0)      act = m_latch || m_cact;
    else if (m_mode == 2) act = m_cact;
    else                  act = m_fhi || m_flo || m_cact;
    return !act;
  endfunction

  function automatic logic [15:0] exp_status();
    return {12'd0, m_fcrit, m_flo, m_fhi, m_latch};
  endfunction

  task automatic model_reset();
    m_en = 0; m_mode = 0; m_hi = 2047; m_lo = -2048; m_crit = 2047; m_hyst = 0;
    m_fhi = 0; m_flo = 0; m_fcrit = 0; m_cact = 0; m_latch = 0;
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      int t;
      bit clr, win;
      t   = sx12(samp_temp);
      clr = wr_en && wr_addr == 3'd5 && wr_data[0];
      win = (t > m_hi) || (t < m_lo);
      if (!m_en) begin
        m_latch = 0; m_cact = 0;
      end else begin
        if (samp_valid) begin
          if (t > m_crit) m_cact = 1;
          else if (t + m_hyst < m_crit) m_cact = 0;
        end
        if (samp_valid && m_mode == 0 && win) m_latch = 1;
        else if (clr) m_latch = 0;
      end
      if (samp_valid) begin
        m_fhi = t > m_hi; m_flo = t < m_lo; m_fcrit = t > m_crit;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_en = wr_data[0]; m_mode = int'(wr_data[2:1]); end
          3'd1: m_hi = sx12(wr_data[11:0]);
          3'd2: m_lo = sx12(wr_data[11:0]);
          3'd3: m_crit = sx12(wr_data[11:0]);
          3'd4: m_hyst = int'(wr_data[11:0]);
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_state(input string req);
    check({req, " event_n"}, {15'd0, event_n}, {15'd0, exp_event_n()});
    check({req, " status"}, rd_data, exp_status());
  endtask

  task automatic do_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_sample(input int t);
    @(negedge clk); samp_valid = 1; samp_temp = 12'(t);
    @(posedge clk);
    @(negedge clk); samp_valid = 0;
  endtask

  task automatic read_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
    rd_addr = a; #0.5;
    check(req, rd_data, exp);
    rd_addr = 3'd5; #0.5;
  endtask

  task automatic ctrl(input bit en, input int mode);
    do_write(3'd0, {13'd0, 2'(mode), en});
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 event_n", {15'd0, event_n}, 16'd1);
    read_chk("R1 status", 3'd5, 16'h0000);
    read_chk("R1 ctrl", 3'd0, 16'h0000);
    read_chk("R1 hi", 3'd1, 16'h07FF);
    read_chk("R1 lo", 3'd2, 16'h0800);
    read_chk("R1 crit", 3'd3, 16'h07FF);
    read_chk("R1 hyst", 3'd4, 16'h0000);

    // R8 programming and readback
    do_write(3'd1, 16'(1280));
    do_write(3'd2, 16'(-160) & 16'h0FFF);
    do_write(3'd3, 16'(1520));
    do_write(3'd4, 16'(32));
    ctrl(1, 1);
    read_chk("R8 hi", 3'd1, 16'h0500);
    read_chk("R8 lo", 3'd2, 16'h0F60);
    read_chk("R8 crit", 3'd3, 16'h05F0);
    read_chk("R8 hyst", 3'd4, 16'h0020);
    read_chk("R8 ctrl", 3'd0, 16'h0003);

    // R2 R3 comparator
    do_sample(1300);  check_state("R3 above");
    check("R2 hi flag", rd_data, 16'h0002);
    do_sample(1000);  check_state("R3 back");
    check("R3 released", {15'd0, event_n}, 16'd1);
    do_sample(-200);  check_state("R3 below");
    check("R2 lo flag", rd_data, 16'h0004);
    do_sample(1280);  check_state("R2 equal hi");
    check("R2 strict", rd_data, 16'h0000);
    do_sample(-160);  check_state("R2 equal lo");

    // R4 latched interrupt
    ctrl(1, 0);
    do_sample(1300);  check_state("R4 set");
    do_sample(1000);  check_state("R4 hold");
    check("R4 held", {15'd0, event_n}, 16'd0);
    do_write(3'd5, 16'h0000); check_state("R4 write zero");
    check("R4 zero no effect", {15'd0, event_n}, 16'd0);
    do_write(3'd5, 16'h0001); check_state("R4 clear");
    check("R4 cleared", {15'd0, event_n}, 16'd1);
    // set wins over clear in the same cycle
    @(negedge clk); samp_valid = 1; samp_temp = 12'(-500);
    wr_en = 1; wr_addr = 3'd5; wr_data = 16'h0001;
    @(posedge clk); @(negedge clk); samp_valid = 0; wr_en = 0;
    check_state("R4 set wins");
    check("R4 set wins latch", {15'd0, rd_data[0]}, 16'd1);
    do_write(3'd5, 16'h0001); check_state("R4 clear again");

    // R5 R6 critical-only with hysteresis
    ctrl(1, 2);
    do_sample(1300);  check_state("R6 window ignored");
    check("R6 event_n", {15'd0, event_n}, 16'd1);
    do_sample(1521);  check_state("R5 crit set");
    do_sample(1500);  check_state("R5 in band");
    do_sample(1488);  check_state("R5 release edge");
    check("R5 still held", {15'd0, event_n}, 16'd0);
    do_sample(1487);  check_state("R5 released");
    check("R5 release", {15'd0, event_n}, 16'd1);
    do_sample(1520);  check_state("R5 equal crit");

    // R7 enable
    do_sample(1600);  check_state("R7 crit on");
    ctrl(0, 2);       check_state("R7 disabled");
    check("R7 forced high", {15'd0, event_n}, 16'd1);
    ctrl(1, 2);       check_state("R7 crit cleared");
    ctrl(1, 0);
    do_sample(1300);  ctrl(0, 0); check_state("R7 off");
    ctrl(1, 0);       check_state("R7 latch cleared");
    check("R7 latch bit", {15'd0, rd_data[0]}, 16'd0);

    // random mix near the limits
    process::self().srandom(32'h1234_5678);
    for (int i = 0; i < 600; i++) begin
      int op, sel, t;
      op = $urandom_range(0, 99);
      if (op < 60) begin
        sel = $urandom_range(0, 4);
        case (sel)
          0: t = m_hi + $urandom_range(0, 6) - 3;
          1: t = m_lo + $urandom_range(0, 6) - 3;
          2: t = m_crit + $urandom_range(0, 6) - 3;
          3: t = m_crit - m_hyst + $urandom_range(0, 4) - 2;
          default: t = $urandom_range(0, 4095) - 2048;
        endcase
        do_sample(t);
      end else if (op < 75) begin
        do_write(3'd5, 16'($urandom_range(0, 1)));
      end else if (op < 87) begin
        ctrl($urandom_range(0, 9) != 0, $urandom_range(0, 3));
      end else if (op < 92) begin
        do_write(3'd4, 16'($urandom_range(0, 64)));
      end else begin
        @(negedge clk);
      end
      check_state("R3 R4 R5 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule